// File: doc/BRIEF.md
# External Status Interrupt Latch Unit

This block collects six condition signals of one serial channel and shows them in a status word that the processor reads. Each condition has its own enable bit. A condition whose enable is clear always appears in the status word at its current synchronized value. A condition whose enable is set is routed through a latch that is shared by all six bits. A change on any enabled condition freezes every enabled bit in the same cycle. A master enable decides whether the frozen state also raises an interrupt-pending flag. The processor reopens the latch by writing a command.

The behaviour is held in a two-state machine:

- `ST_OPEN`: the latch follows the inputs.
- `ST_CLOSED`: the latch holds a snapshot.

There are two transitions:

- `FREEZE` (`ST_OPEN` to `ST_CLOSED`) is taken when an enabled condition differs from its previous synchronized value.
- `REOPEN` (`ST_CLOSED` to `ST_OPEN`) is taken when the reopen command is written.

The comparison register is held while the latch is closed, so it keeps the snapshot. If the inputs changed while the latch was closed, the first open cycle sees the difference and freezes again. No event is lost.

Top module: `exst_latch_unit`

## Requirements
- R1: After reset the machine is in `ST_OPEN`, `pend_o` is 0, the master enable is 0 and all six condition enables are 0.
- R2: `cond_i[k]` appears at `stat_o[k]` two rising edges after it is applied (two-flop synchronizer). The bit order is: 0 baud-generator zero count, 1 carrier detect, 2 sync/hunt, 3 clear to send, 4 transmit underrun/end of message, 5 break/abort.
- R3: A status bit whose enable is 0 always shows the live synchronized input, whatever state the machine is in.
- R4: A status bit whose enable is 1 shows the live value in `ST_OPEN`. In `ST_CLOSED` it shows the value captured at the `FREEZE` edge.
- R5: `FREEZE` happens one edge after a synchronized enabled input changes, and it freezes all enabled bits together. Changes on inputs whose enable is 0 never cause `FREEZE`.
- R6: Writing `wr_data_i == 6'd2` with `wr_sel_i == 2'd0` takes `REOPEN` at that edge. Any other value written with select 0 leaves the state unchanged.
- R7: `pend_o` is 1 exactly when the machine is in `ST_CLOSED` and the master enable is 1.
- R8: With the master enable at 0, `pend_o` stays 0, but `FREEZE` and `REOPEN` still occur as usual.
- R9: If an enabled input differs from the snapshot when `REOPEN` is taken, whether it changed while the latch was closed or in the same cycle as the command, `FREEZE` follows at the next edge.
- R10: A write with `wr_sel_i == 2'd1` loads the master enable from `wr_data_i[0]`. A write with `wr_sel_i == 2'd2` loads the six enables from `wr_data_i[5:0]`. Select 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cond_i | input | 6 | Asynchronous condition inputs |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 command, 1 master, 2 enables |
| wr_data_i | input | 6 | Write data |
| stat_o | output | 6 | Status word |
| pend_o | output | 1 | Interrupt pending |

## Verification
The bench sweeps each of the six bits as the only enabled source. It checks that toggling the bit back after `FREEZE` leaves the frozen value visible. A design that latched bits independently, or kept following the input, would show 0 there. It toggles only disabled inputs to catch a change detector that ignores the enable mask. It issues `REOPEN` while the input differs from the snapshot, expecting a second `FREEZE` one edge later. A design that resampled the comparison register while closed would miss that event. It also runs with the master enable cleared and writes a wrong command value, expecting the latch still to freeze and no reopen to happen.

// File: rtl/exst_pkg.sv
package exst_pkg;
    localparam int unsigned NCOND = 6;
    localparam int unsigned SEL_W = 2;

    typedef enum logic [0:0] {
        ST_OPEN   = 1'b0,
        ST_CLOSED = 1'b1
    } latch_state_e;

    localparam logic [SEL_W-1:0] SEL_CMD    = 2'd0;
    localparam logic [SEL_W-1:0] SEL_MASTER = 2'd1;
    localparam logic [SEL_W-1:0] SEL_ENAB   = 2'd2;
    localparam logic [NCOND-1:0] CMD_REOPEN = 6'd2;
endpackage

// File: rtl/exst_sync.sv
module exst_sync #(
    parameter int unsigned WIDTH = 6
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic meta_q;
        logic stab_q;
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
            end else begin
                meta_q <= d_i[g];
                stab_q <= meta_q;
            end
        end
        assign q_o[g] = stab_q;
    end
endmodule

// File: rtl/exst_regs.sv
module exst_regs
    import exst_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_en_i,
    input  logic [SEL_W-1:0] wr_sel_i,
    input  logic [NCOND-1:0] wr_data_i,
    output logic             master_o,
    output logic [NCOND-1:0] ie_o,
    output logic             reopen_o
);
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            master_o <= 1'b0;
            ie_o     <= '0;
        end else if (wr_en_i) begin
            if (wr_sel_i == SEL_MASTER) master_o <= wr_data_i[0];
            if (wr_sel_i == SEL_ENAB)   ie_o     <= wr_data_i;
        end
    end

    always_comb reopen_o = wr_en_i && (wr_sel_i == SEL_CMD) && (wr_data_i == CMD_REOPEN);

    // R1
    reg_reset_chk: assert property (@(posedge clk_i)
        $rose(rst_ni) |-> (ie_o == '0) && !master_o);
endmodule

// File: rtl/exst_latch_fsm.sv
module exst_latch_fsm
    import exst_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [NCOND-1:0] live_i,
    input  logic [NCOND-1:0] ie_i,
    input  logic             master_i,
    input  logic             reopen_i,
    output logic [NCOND-1:0] stat_o,
    output logic             pend_o
);
    latch_state_e     state_q, state_d;
    logic [NCOND-1:0] snap_q;
    logic             change;

    always_comb change = |((live_i ^ snap_q) & ie_i);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPEN:   if (change)   state_d = ST_CLOSED;
            ST_CLOSED: if (reopen_i) state_d = ST_OPEN;
            default:                 state_d = ST_OPEN;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_OPEN;
            snap_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_OPEN) snap_q <= live_i;
        end
    end

    always_comb begin
        pend_o = 1'b0;
        stat_o = live_i;
        unique case (state_q)
            ST_OPEN: begin
                pend_o = 1'b0;
                stat_o = live_i;
            end
            ST_CLOSED: begin
                pend_o = master_i;
                stat_o = (live_i & ~ie_i) | (snap_q & ie_i);
            end
            default: begin
                pend_o = 1'b0;
                stat_o = live_i;
            end
        endcase
    end

    // R5
    freeze_on_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_OPEN && change) |=> (state_q == ST_CLOSED));
    // R4
    snap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_CLOSED && !reopen_i) |=> $stable(snap_q) && (state_q == ST_CLOSED));
    // R6
    reopen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_CLOSED && reopen_i) |=> (state_q == ST_OPEN));
    // R8
    no_pend_wo_master_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !master_i |-> !pend_o);
    // R3
    live_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((stat_o ^ live_i) & ~ie_i) == '0);
endmodule

// File: rtl/exst_latch_unit.sv
module exst_latch_unit
    import exst_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [5:0]       cond_i,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_sel_i,
    input  logic [5:0]       wr_data_i,
    output logic [5:0]       stat_o,
    output logic             pend_o
);
    logic [NCOND-1:0] live;
    logic [NCOND-1:0] ie;
    logic             master;
    logic             reopen;

    exst_sync #(.WIDTH(NCOND)) sync_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (cond_i),
        .q_o    (live)
    );

    exst_regs regs_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .wr_sel_i  (wr_sel_i),
        .wr_data_i (wr_data_i),
        .master_o  (master),
        .ie_o      (ie),
        .reopen_o  (reopen)
    );

    exst_latch_fsm fsm_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .live_i   (live),
        .ie_i     (ie),
        .master_i (master),
        .reopen_i (reopen),
        .stat_o   (stat_o),
        .pend_o   (pend_o)
    );

    // R2
    sync_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) || 1'b1 |=> ##1 (live == $past(cond_i, 2)) || $past(!rst_ni, 2) || $past(!rst_ni, 1));
endmodule

// File: tb/exst_latch_unit_tb_top.sv
module exst_latch_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] cond = '0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = '0;
    logic [5:0] wr_data = '0;
    logic [5:0] stat;
    logic       pend;
    int         n_run = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    exst_latch_unit dut_i (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .cond_i    (cond),
        .wr_en_i   (wr_en),
        .wr_sel_i  (wr_sel),
        .wr_data_i (wr_data),
        .stat_o    (stat),
        .pend_o    (pend)
    );

    task automatic chk(input string req, input logic [6:0] got, input logic [6:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%b exp=%b", req, got, exp);
        end
    endtask

    task automatic edges(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [5:0] d);
        wr_sel = sel; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        edges(2);
        // R1: reset state, live zero inputs
        chk("R1", {pend, stat}, 7'd0);
        rst_n = 1'b1;
        edges(1);
        // R1 enables zero: master on, toggle all inputs, nothing freezes
        wr(2'd1, 6'd1);
        cond = 6'h2A;
        edges(1);
        chk("R2", {pend, stat}, 7'd0);
        edges(1);
        chk("R2", {pend, stat}, {1'b0, 6'h2A});
        edges(2);
        chk("R1", {pend, stat}, {1'b0, 6'h2A});
        cond = 6'h15;
        edges(3);
        chk("R3", {pend, stat}, {1'b0, 6'h15});
        cond = '0;
        edges(3);
        for (int i = 0; i < 6; i++) begin
            logic [5:0] m;
            m = 6'(1 << i);
            wr(2'd2, m);
            // R5: disabled inputs toggling do not freeze
            cond = ~m;
            edges(3);
            chk("R5", {pend, stat}, {1'b0, ~m});
            cond = '0;
            edges(3);
            cond = m;
            edges(2);
            chk("R4", {pend, stat}, {1'b0, m});
            edges(1);
            chk("R7", {pend, stat}, {1'b1, m});
            // R4: enabled bit frozen, others live (R3)
            cond = ~m;
            edges(3);
            chk("R4", {pend, stat}, {1'b1, 6'h3F});
            cond = '0;
            edges(3);
            chk("R4", {pend, stat}, {1'b1, m});
            // R6: wrong command keeps latch closed; select 3 ignored (R10)
            wr(2'd0, 6'd1);
            wr(2'd3, 6'd2);
            chk("R6", {pend, stat}, {1'b1, m});
            // R9: reopen with input differing from snapshot
            wr(2'd0, 6'd2);
            chk("R6", {pend, stat}, 7'd0);
            edges(1);
            chk("R9", {pend, stat}, {1'b1, 6'd0});
            wr(2'd0, 6'd2);
            edges(2);
            chk("R6", {pend, stat}, 7'd0);
        end
        // R8: master off, latch still freezes
        wr(2'd1, 6'd0);
        wr(2'd2, 6'h09);
        cond = 6'h08;
        edges(4);
        chk("R8", {pend, stat}, {1'b0, 6'h08});
        cond = 6'h07;
        edges(3);
        chk("R8", {pend, stat}, {1'b0, 6'h0E});
        // R10: master enabled again while closed raises pending (R7)
        wr(2'd1, 6'd1);
        chk("R10", {pend, stat}, {1'b1, 6'h0E});
        wr(2'd1, 6'd0);
        chk("R7", {pend, stat}, {1'b0, 6'h0E});
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog got=hang exp=done");
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule